// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display. A horizontal counter walks each line and a vertical counter walks each frame. From the two counters the block derives an active-video enable, a horizontal and a vertical sync pulse, a composite sync indication meant for embedding sync in the colour signal, and a one-cycle early-fetch pulse. The early-fetch pulse lets the pixel pipeline start loading the next line before the current line ends. Every timing value is written by software over a simple register bus. Each one is stored as a last-position value, meaning the position minus one.

A two-state run sequencer controls the counters. In state OFF the counters are held at zero and all outputs stay idle. In state RUN the counters advance once per pixel clock. The sequencer takes the transition OFF→RUN when the control run bit is set, and RUN→OFF when that bit is cleared. Software clears the run bit while it reprograms the timing and sets it again afterwards.

A sync-mode register sets the polarity of each sync and can suppress the horizontal sync, the vertical sync or both, for power-saving blanking. A display register can force the video enable low. All outputs are registered and aligned with the reported pixel position.

Top module: `raster_timing_gen`

## Requirements
- R1: During reset and right after it is released, every register reads 0, the sequencer is in OFF, pix_x and pix_y are 0, and vid_en, hsync_o, vsync_o, rgb_sync and fetch_pulse are all low.
- R2: The register indices on reg_addr are:
    - 0: control; bit0 is run and bit1 is refresh.
    - 1: line last.
    - 2: visible-width last.
    - 3: hsync begin.
    - 4: hsync finish.
    - 5: frame last line.
    - 6: visible-height last.
    - 7: vsync begin.
    - 8: vsync finish.
    - 9: fetch position.
    - 10: sync mode.
    - 11: display; bit1 is blank.

  A write with reg_wr high is stored on the clock edge. reg_rdata returns the stored value combinationally, zero-extended. Timing registers keep their low HW or VW bits. The control register keeps bits 1:0. The sync mode register keeps bits 6:3 and 1:0, and bit2 reads 0. The display register keeps bit1 only. Indices 12 to 15 read 0.
- R3: While running, pix_x counts from 0 up to line last and then returns to 0. On that return pix_y advances. pix_y returns to 0 after frame last line, so one frame lasts (line last+1)×(frame last line+1) cycles.
- R4: vid_en is high exactly when all of these hold: pix_x ≤ visible-width last, pix_y ≤ visible-height last, the refresh bit is set and the display blank bit is clear.
- R5: The horizontal sync is active for pix_x from hsync begin+1 through hsync finish. The vertical sync is active for whole lines, with pix_y from vsync begin+1 through vsync finish.
- R6: Sync mode bit3 inverts hsync_o and bit4 inverts vsync_o. With those bits clear, both syncs are active high.
- R7: Sync mode bit5 holds hsync_o at its inactive level, bit6 does the same for vsync_o, and bit1 does it for both. The inactive level equals the inversion bit.
- R8: With sync mode bit0 set, rgb_sync is high whenever either sync is active and not suppressed. With bit0 clear, rgb_sync stays low.
- R9: The display blank bit forces vid_en low from the cycle after it is set. The syncs keep running.
- R10: fetch_pulse is high for one cycle on every line, blanking lines included, when pix_x equals the fetch position.
- R11: Clearing the run bit moves the sequencer to OFF. Within three cycles pix_x and pix_y are 0, vid_en and fetch_pulse are low, and both syncs are at their inactive level. Setting the run bit moves it to RUN on the next edge, and the output at position (0,0) appears two edges after the write.
- R12: Every output comes from a flop. The values on a given cycle describe the pixel reported on pix_x and pix_y.
- R13: With the default widths, the 1280x1024 mode fits. This mode has line last 1687, visible-width last 1279, hsync 1327/1439, frame last line 1065, visible-height last 1023 and vsync 1024/1027.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register index |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| pix_x | output | HW | Horizontal position of current output cycle |
| pix_y | output | VW | Vertical position of current output cycle |
| vid_en | output | 1 | Active-video enable |
| hsync_o | output | 1 | Horizontal sync after polarity and suppression |
| vsync_o | output | 1 | Vertical sync after polarity and suppression |
| rgb_sync | output | 1 | Composite sync for embedding in colour |
| fetch_pulse | output | 1 | One-cycle early line-fetch pulse |

## Verification
The bench builds the block with its default widths: 12-bit horizontal and vertical counters, a 32-bit data bus and a 4-bit index. With these widths the full 1280x1024 line, 1688 pixels long, can be checked directly. Small programmed modes of a few hundred cycles per frame bring frame wrap, vertical sync windows, fetch pulses on blanking lines, and every polarity and suppression combination within reach. A separate directed run on the large mode covers one full line of the default timing.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    // register indices (decoded by software drivers, fixed)
    typedef enum logic [3:0] {
        IDX_CTRL    = 4'd0,
        IDX_H_LAST  = 4'd1,
        IDX_H_VIS   = 4'd2,
        IDX_HS_BEG  = 4'd3,
        IDX_HS_FIN  = 4'd4,
        IDX_V_LAST  = 4'd5,
        IDX_V_VIS   = 4'd6,
        IDX_VS_BEG  = 4'd7,
        IDX_VS_FIN  = 4'd8,
        IDX_FETCH   = 4'd9,
        IDX_SYNC    = 4'd10,
        IDX_DISP    = 4'd11
    } reg_idx_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_REFR_BIT  = 1;

    localparam int SC_RGB_BIT     = 0;
    localparam int SC_ALLOFF_BIT  = 1;
    localparam int SC_HINV_BIT    = 3;
    localparam int SC_VINV_BIT    = 4;
    localparam int SC_HOFF_BIT    = 5;
    localparam int SC_VOFF_BIT    = 6;

    localparam int DISP_BLANK_BIT = 1;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    typedef struct packed {
        logic rgb;
        logic all_off;
        logic h_inv;
        logic v_inv;
        logic h_off;
        logic v_off;
    } sync_mode_t;

endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          tim_en,
    output logic          refr_en,
    output logic          disp_blank,
    output sync_mode_t    smode,
    output logic [HW-1:0] h_last,
    output logic [HW-1:0] h_vis,
    output logic [HW-1:0] hs_beg,
    output logic [HW-1:0] hs_fin,
    output logic [HW-1:0] fetch_pos,
    output logic [VW-1:0] v_last,
    output logic [VW-1:0] v_vis,
    output logic [VW-1:0] vs_beg,
    output logic [VW-1:0] vs_fin
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_en     <= 1'b0;
            refr_en    <= 1'b0;
            disp_blank <= 1'b0;
            smode      <= '0;
            h_last     <= '0;
            h_vis      <= '0;
            hs_beg     <= '0;
            hs_fin     <= '0;
            fetch_pos  <= '0;
            v_last     <= '0;
            v_vis      <= '0;
            vs_beg     <= '0;
            vs_fin     <= '0;
        end else if (wr) begin
            case (addr)
                AW'(IDX_CTRL): begin
                    tim_en  <= wdata[CTRL_RUN_BIT];
                    refr_en <= wdata[CTRL_REFR_BIT];
                end
                AW'(IDX_H_LAST): h_last    <= wdata[HW-1:0];
                AW'(IDX_H_VIS):  h_vis     <= wdata[HW-1:0];
                AW'(IDX_HS_BEG): hs_beg    <= wdata[HW-1:0];
                AW'(IDX_HS_FIN): hs_fin    <= wdata[HW-1:0];
                AW'(IDX_V_LAST): v_last    <= wdata[VW-1:0];
                AW'(IDX_V_VIS):  v_vis     <= wdata[VW-1:0];
                AW'(IDX_VS_BEG): vs_beg    <= wdata[VW-1:0];
                AW'(IDX_VS_FIN): vs_fin    <= wdata[VW-1:0];
                AW'(IDX_FETCH):  fetch_pos <= wdata[HW-1:0];
                AW'(IDX_SYNC): begin
                    smode.rgb     <= wdata[SC_RGB_BIT];
                    smode.all_off <= wdata[SC_ALLOFF_BIT];
                    smode.h_inv   <= wdata[SC_HINV_BIT];
                    smode.v_inv   <= wdata[SC_VINV_BIT];
                    smode.h_off   <= wdata[SC_HOFF_BIT];
                    smode.v_off   <= wdata[SC_VOFF_BIT];
                end
                AW'(IDX_DISP):   disp_blank <= wdata[DISP_BLANK_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(IDX_CTRL): begin
                rdata[CTRL_RUN_BIT]  = tim_en;
                rdata[CTRL_REFR_BIT] = refr_en;
            end
            AW'(IDX_H_LAST): rdata = DW'(h_last);
            AW'(IDX_H_VIS):  rdata = DW'(h_vis);
            AW'(IDX_HS_BEG): rdata = DW'(hs_beg);
            AW'(IDX_HS_FIN): rdata = DW'(hs_fin);
            AW'(IDX_V_LAST): rdata = DW'(v_last);
            AW'(IDX_V_VIS):  rdata = DW'(v_vis);
            AW'(IDX_VS_BEG): rdata = DW'(vs_beg);
            AW'(IDX_VS_FIN): rdata = DW'(vs_fin);
            AW'(IDX_FETCH):  rdata = DW'(fetch_pos);
            AW'(IDX_SYNC): begin
                rdata[SC_RGB_BIT]    = smode.rgb;
                rdata[SC_ALLOFF_BIT] = smode.all_off;
                rdata[SC_HINV_BIT]   = smode.h_inv;
                rdata[SC_VINV_BIT]   = smode.v_inv;
                rdata[SC_HOFF_BIT]   = smode.h_off;
                rdata[SC_VOFF_BIT]   = smode.v_off;
            end
            AW'(IDX_DISP): rdata[DISP_BLANK_BIT] = disp_blank;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtg_run_fsm.sv
module rtg_run_fsm
    import rtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tim_en,
    output logic run,
    output logic cnt_clr
);

    run_state_e state_q;
    run_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: OFF->RUN on run bit set, RUN->OFF on run bit clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (tim_en)  state_d = ST_RUN;
            ST_RUN: if (!tim_en) state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_OFF: cnt_clr = 1'b1;
            ST_RUN: run     = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtg_scan_cnt.sv
module rtg_scan_cnt #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [HW-1:0] h_last,
    input  logic [VW-1:0] v_last,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt
);

    logic h_end;
    logic v_end;

    // ">=" so a shortened line after reprogramming still wraps at once
    assign h_end = (h_cnt >= h_last);
    assign v_end = (v_cnt >= v_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (clr) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (adv) begin
            if (h_end) begin
                h_cnt <= '0;
                v_cnt <= v_end ? '0 : v_cnt + 1'b1;
            end else begin
                h_cnt <= h_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtg_out_stage.sv
module rtg_out_stage
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          refr_en,
    input  logic          disp_blank,
    input  sync_mode_t    smode,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic [HW-1:0] h_vis,
    input  logic [HW-1:0] hs_beg,
    input  logic [HW-1:0] hs_fin,
    input  logic [HW-1:0] fetch_pos,
    input  logic [VW-1:0] v_vis,
    input  logic [VW-1:0] vs_beg,
    input  logic [VW-1:0] vs_fin,
    output logic [HW-1:0] pix_x,
    output logic [VW-1:0] pix_y,
    output logic          vid_en,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          rgb_sync,
    output logic          fetch_pulse
);

    logic in_vis;
    logic h_win;
    logic v_win;
    logic h_on;
    logic v_on;

    always_comb begin
        in_vis = (h_cnt <= h_vis) && (v_cnt <= v_vis);
        h_win  = (h_cnt > hs_beg) && (h_cnt <= hs_fin);
        v_win  = (v_cnt > vs_beg) && (v_cnt <= vs_fin);
        h_on   = run && h_win && !smode.h_off && !smode.all_off;
        v_on   = run && v_win && !smode.v_off && !smode.all_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_x       <= '0;
            pix_y       <= '0;
            vid_en      <= 1'b0;
            hsync_o     <= 1'b0;
            vsync_o     <= 1'b0;
            rgb_sync    <= 1'b0;
            fetch_pulse <= 1'b0;
        end else begin
            pix_x       <= h_cnt;
            pix_y       <= v_cnt;
            vid_en      <= run && refr_en && !disp_blank && in_vis;
            hsync_o     <= h_on ^ smode.h_inv;
            vsync_o     <= v_on ^ smode.v_inv;
            rgb_sync    <= smode.rgb && (h_on || v_on);
            fetch_pulse <= run && (h_cnt == fetch_pos);
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [HW-1:0] pix_x,
    output logic [VW-1:0] pix_y,
    output logic          vid_en,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          rgb_sync,
    output logic          fetch_pulse
);

    logic          tim_en;
    logic          refr_en;
    logic          disp_blank;
    sync_mode_t    smode;
    logic [HW-1:0] h_last, h_vis, hs_beg, hs_fin, fetch_pos;
    logic [VW-1:0] v_last, v_vis, vs_beg, vs_fin;
    logic          run_w;
    logic          cnt_clr;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;

    rtg_regfile #(.HW(HW), .VW(VW), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .tim_en     (tim_en),
        .refr_en    (refr_en),
        .disp_blank (disp_blank),
        .smode      (smode),
        .h_last     (h_last),
        .h_vis      (h_vis),
        .hs_beg     (hs_beg),
        .hs_fin     (hs_fin),
        .fetch_pos  (fetch_pos),
        .v_last     (v_last),
        .v_vis      (v_vis),
        .vs_beg     (vs_beg),
        .vs_fin     (vs_fin)
    );

    rtg_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tim_en  (tim_en),
        .run     (run_w),
        .cnt_clr (cnt_clr)
    );

    rtg_scan_cnt #(.HW(HW), .VW(VW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .adv    (run_w),
        .h_last (h_last),
        .v_last (v_last),
        .h_cnt  (h_cnt),
        .v_cnt  (v_cnt)
    );

    rtg_out_stage #(.HW(HW), .VW(VW)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_w),
        .refr_en     (refr_en),
        .disp_blank  (disp_blank),
        .smode       (smode),
        .h_cnt       (h_cnt),
        .v_cnt       (v_cnt),
        .h_vis       (h_vis),
        .hs_beg      (hs_beg),
        .hs_fin      (hs_fin),
        .fetch_pos   (fetch_pos),
        .v_vis       (v_vis),
        .vs_beg      (vs_beg),
        .vs_fin      (vs_fin),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .vid_en      (vid_en),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .rgb_sync    (rgb_sync),
        .fetch_pulse (fetch_pulse)
    );

endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          all_off,
    input logic          h_inv,
    input logic          v_inv,
    input logic          disp_blank,
    input logic [HW-1:0] fetch_pos,
    input logic [HW-1:0] pix_x,
    input logic [VW-1:0] pix_y,
    input logic          vid_en,
    input logic          hsync_o,
    input logic          vsync_o,
    input logic          fetch_pulse
);

    // R3
    h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pix_x == '0 || pix_x == $past(pix_x) + 1'b1));

    // R11
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |=> (pix_x == '0 && pix_y == '0 && !vid_en && !fetch_pulse));

    // R9
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_blank |=> !vid_en);

    // R7
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> (hsync_o == $past(h_inv) && vsync_o == $past(v_inv)));

    // R10
    fetch_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pulse |-> (pix_x == $past(fetch_pos)));

endmodule

bind raster_timing_gen rtg_chk #(.HW(HW), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_w),
    .all_off     (smode.all_off),
    .h_inv       (smode.h_inv),
    .v_inv       (smode.v_inv),
    .disp_blank  (disp_blank),
    .fetch_pos   (fetch_pos),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .vid_en      (vid_en),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .fetch_pulse (fetch_pulse)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam int HW = 12;
    localparam int VW = 12;
    localparam int DW = 32;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [HW-1:0] pix_x;
    logic [VW-1:0] pix_y;
    logic          vid_en, hsync_o, vsync_o, rgb_sync, fetch_pulse;

    raster_timing_gen #(.HW(HW), .VW(VW), .DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_x(pix_x),
        .pix_y(pix_y), .vid_en(vid_en), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .rgb_sync(rgb_sync), .fetch_pulse(fetch_pulse)
    );

    // ht ha hss hse vt va vss vse pf sc
    typedef struct packed {
        logic [11:0] ht, ha, hss, hse, vt, va, vss, vse, pf;
        logic [6:0]  sc;
    } mode_t;

    localparam int NMODES = 5;
    localparam mode_t MODES [NMODES] = '{
        '{12'd19, 12'd11, 12'd13, 12'd16, 12'd9,  12'd5, 12'd6, 12'd8,  12'd15, 7'h00},
        '{12'd15, 12'd9,  12'd10, 12'd12, 12'd7,  12'd3, 12'd4, 12'd5,  12'd14, 7'h19},
        '{12'd23, 12'd15, 12'd17, 12'd21, 12'd5,  12'd2, 12'd3, 12'd4,  12'd0,  7'h20},
        '{12'd11, 12'd7,  12'd8,  12'd10, 12'd11, 12'd8, 12'd9, 12'd11, 12'd11, 7'h41},
        '{12'd9,  12'd5,  12'd6,  12'd8,  12'd6,  12'd3, 12'd4, 12'd5,  12'd3,  7'h1B}
    };

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = AW'(idx);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = AW'(idx);
        #2;
        d = reg_rdata;
    endtask

    task automatic load(input mode_t m, input logic [1:0] ctrl, input logic blank);
        wr(0, 0);
        wr(1, DW'(m.ht));  wr(2, DW'(m.ha));  wr(3, DW'(m.hss)); wr(4, DW'(m.hse));
        wr(5, DW'(m.vt));  wr(6, DW'(m.va));  wr(7, DW'(m.vss)); wr(8, DW'(m.vse));
        wr(9, DW'(m.pf));  wr(10, DW'(m.sc)); wr(11, {30'b0, blank, 1'b0});
        wr(0, DW'(ctrl));
    endtask

    // waits for a frame wrap, then measures exactly one frame
    task automatic run_frame(input mode_t m, input bit de_on, input string tag);
        int n, hlen, vlen, e_hs, e_vs, e_rgb, e_de;
        int n_de, n_hs, n_vs, n_pf, n_rgb;
        bit hon, von, seen_nz;
        logic [HW-1:0] lx;
        logic [VW-1:0] ly;
        n = (int'(m.ht) + 1) * (int'(m.vt) + 1);
        n_de = 0; n_hs = 0; n_vs = 0; n_pf = 0; n_rgb = 0;
        lx = '0; ly = '0;
        seen_nz = 1'b0;
        @(negedge clk);
        while (!(seen_nz && pix_x == 0 && pix_y == 0)) begin
            if (pix_x != 0 || pix_y != 0) seen_nz = 1'b1;
            @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            if (vid_en) n_de++;
            if (hsync_o != m.sc[3]) n_hs++;
            if (vsync_o != m.sc[4]) n_vs++;
            if (fetch_pulse) n_pf++;
            if (rgb_sync) n_rgb++;
            lx = pix_x;
            ly = pix_y;
            @(negedge clk);
        end
        hlen = int'(m.hse) - int'(m.hss);
        vlen = int'(m.vse) - int'(m.vss);
        hon = !(m.sc[5] || m.sc[1]);
        von = !(m.sc[6] || m.sc[1]);
        e_hs = hon ? hlen * (int'(m.vt) + 1) : 0;
        e_vs = von ? vlen * (int'(m.ht) + 1) : 0;
        e_rgb = m.sc[0] ? (e_hs + e_vs - ((hon && von) ? hlen * vlen : 0)) : 0;
        e_de = de_on ? (int'(m.ha) + 1) * (int'(m.va) + 1) : 0;
        chk("R3",  {tag, " last x of frame"}, lx, m.ht);
        chk("R3",  {tag, " last y of frame"}, ly, m.vt);
        chk("R3",  {tag, " wrap to origin"}, pix_x + pix_y, 0);
        chk("R4",  {tag, " vid_en cycles"}, n_de, e_de);
        chk("R5 R6 R7", {tag, " hsync active cycles"}, n_hs, e_hs);
        chk("R5 R6 R7", {tag, " vsync active cycles"}, n_vs, e_vs);
        chk("R10", {tag, " fetch pulses"}, n_pf, int'(m.vt) + 1);
        chk("R8",  {tag, " rgb_sync cycles"}, n_rgb, e_rgb);
    endtask

    initial begin
        logic [DW-1:0] d;
        int errs;
        mode_t dm;
        int n_de, n_hs, first_hs, pf_x, n_pf;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", {vid_en, hsync_o, vsync_o, rgb_sync, fetch_pulse}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "outputs after reset", {vid_en, hsync_o, vsync_o, rgb_sync, fetch_pulse}, 0);
        chk("R1", "position after reset", pix_x + pix_y, 0);
        errs = 0;
        for (int i = 0; i < 16; i++) begin
            rd(i, d);
            if (d != 0) errs++;
        end
        chk("R1", "registers nonzero after reset", errs, 0);

        // R2: register storage and masking
        errs = 0;
        for (int i = 1; i <= 9; i++) wr(i, 32'hF000_0000 | DW'(i * 300));
        for (int i = 1; i <= 9; i++) begin
            rd(i, d);
            if (d != DW'(i * 300)) errs++;
        end
        chk("R2", "timing register readback errors", errs, 0);
        wr(10, 32'hFFFF_FFFF);
        rd(10, d);
        chk("R2", "sync mode readback", d, 32'h7B);
        wr(11, 32'hFFFF_FFFF);
        rd(11, d);
        chk("R2", "display readback", d, 32'h2);
        wr(15, 32'hFFFF_FFFF);
        rd(15, d);
        chk("R2", "unmapped index readback", d, 0);
        wr(0, 32'hFFFF_FFFC);
        rd(0, d);
        chk("R2", "control keeps bits 1:0", d, 0);
        wr(11, 0);
        wr(10, 0);

        // table of modes
        for (int k = 0; k < NMODES; k++) begin
            load(MODES[k], 2'b11, 1'b0);
            run_frame(MODES[k], 1'b1, $sformatf("mode%0d", k));
        end

        // R9: display blank, syncs still present
        load(MODES[0], 2'b11, 1'b1);
        run_frame(MODES[0], 1'b0, "R9 blank");

        // R4: refresh bit clear keeps vid_en low
        load(MODES[0], 2'b01, 1'b0);
        run_frame(MODES[0], 1'b0, "R4 no refresh");

        // R11: sequencer OFF holds counters, syncs at inverted idle level
        load(MODES[1], 2'b00, 1'b0);
        errs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pix_x != 0 || pix_y != 0 || vid_en || fetch_pulse || !hsync_o || !vsync_o) errs++;
        end
        chk("R11", "idle cycles with activity", errs, 0);
        wr(0, 32'h3);
        @(negedge clk);
        chk("R11", "vid_en one edge after run write", vid_en, 0);
        @(negedge clk);
        chk("R11", "origin output two edges after run write", {vid_en, pix_x}, {1'b1, 12'd0});
        @(negedge clk);
        chk("R12", "x advances next cycle", pix_x, 1);
        repeat (35) @(negedge clk);
        wr(0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R11", "stopped position", pix_x + pix_y, 0);
        chk("R11", "stopped outputs", {vid_en, fetch_pulse, hsync_o, vsync_o}, 4'b0011);

        // R13: one full line of the 1280x1024 mode
        dm = '{12'd1687, 12'd1279, 12'd1327, 12'd1439, 12'd1065, 12'd1023,
               12'd1024, 12'd1027, 12'd1332, 7'h00};
        load(dm, 2'b11, 1'b0);
        @(negedge clk);
        while (!vid_en) @(negedge clk);
        n_de = 0; n_hs = 0; first_hs = -1; pf_x = -1; n_pf = 0;
        for (int i = 0; i < 1688; i++) begin
            if (vid_en) n_de++;
            if (hsync_o) begin
                n_hs++;
                if (first_hs < 0) first_hs = int'(pix_x);
            end
            if (fetch_pulse) begin
                n_pf++;
                pf_x = int'(pix_x);
            end
            @(negedge clk);
        end
        chk("R13", "visible pixels in line", n_de, 1280);
        chk("R13", "hsync length", n_hs, 112);
        chk("R13 R5", "first hsync position", first_hs, 1328);
        chk("R13 R10", "fetch position", pf_x, 1332);
        chk("R13 R10", "fetch count in line", n_pf, 1);
        chk("R13 R3", "next line start", {pix_x, pix_y}, {12'd0, 12'd1});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule